// File: doc/BRIEF.md
# Half-Duplex Serial Flash Master with Opcode Buffer

This block is a register-mapped SPI master aimed at serial flash devices. Software fills a 32-bit opcode word and a 32-byte data buffer. It then sets three bit counts: one for the opcode phase, one for outgoing data and one for incoming data. Writing the start bit runs one transaction with no overlap between directions. The opcode bits go out first, the buffered data follows, and the returning bits are captured last, back into the same buffer.

The serial clock rate comes from a programmable divider. Clock polarity, clock phase and bit order within a byte are selectable. Chip-select lines are under direct software control, so a device can stay selected across several transactions. A busy flag covers the whole of the bus activity.

Top module: `spim_top`

## Requirements
- R1: Registers sit at byte addresses 0x00 (control), 0x04 (opcode), 0x08..0x24 (data words 0..7), 0x28 (configuration), 0x2C (lengths) and 0x38 (chip select). In the configuration register, bit 3 selects LSB-first, bit 4 is clock polarity, bit 5 is clock phase and bits [27:16] hold the divider value d. Reading the configuration register returns those fields and zero elsewhere. The lengths register reads back as written.
- R2: Writing 1 to bit 8 of the control register starts a transaction. Bit 16 of the control register reads 1 from the clock edge that accepts the start until the last bit time ends. Bit 8 always reads 0.
- R3: A start write made while busy is 1 is ignored, and the running transaction keeps its length.
- R4: The lengths register holds the opcode bit count in bits [31:24], the receive bit count in bits [23:12] and the transmit bit count in bits [11:0]. The opcode phase goes first and sends opcode bits from bit (count-1) down to bit 0. The transmit phase follows, then the receive phase, with no gaps between them.
- R5: Data byte n sits in word n/4 at bits 8*(n mod 4). Bytes go out in increasing n. Within each byte the MSB goes first, unless LSB-first is set. LSB-first does not affect the opcode phase.
- R6: Received bits are written into the data buffer from byte 0 upward, using the same byte and bit mapping as transmit. MOSI is 0 during every receive bit time.
- R7: Each bit time lasts d+2 system clocks. A transaction of N total bits keeps busy at 1 for exactly N*(d+2) cycles.
- R8: SCK idles at the polarity level. With phase 0, data is sampled on the first edge of each bit. With phase 1, data is sampled on the second edge. Exactly one sampling edge occurs per bit.
- R9: Chip-select output i is driven low (active) while bit i of the chip-select register is 1. The outputs do not change during or after a transaction. They read all high after reset.
- R10: An opcode count above 32 is treated as 32. Transmit and receive counts above 256 are each treated as 256.
- R11: A start with all three counts at 0 does nothing: busy stays 0 and SCK does not toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 8 | Register byte address |
| busWrEn | input | 1 | Register write strobe |
| busWrData | input | 32 | Register write data |
| busRdData | output | 32 | Register read data (combinational) |
| spiSck | output | 1 | Serial clock |
| spiMosi | output | 1 | Serial data out |
| spiMiso | input | 1 | Serial data in |
| spiCsN | output | NUM_CS | Active-low chip selects |

## Verification
The hardest case to reach from the ports is a start request that arrives while a transaction is still running. The bench writes the start bit again two cycles into a long transfer. It then checks that busy stays high for exactly the original N*(d+2) cycles. Phase boundaries are the other hard case, in particular an opcode phase that flows straight into the receive phase, or counts that exceed the limits. Randomly drawn counts, modes and dividers, together with directed transfers at the length limits and at the largest divider, cover these.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int DATA_BYTES = 32;
  localparam int BUF_BITS   = DATA_BYTES * 8;
  localparam int DATA_WORDS = DATA_BYTES / 4;
  localparam int IDX_W      = $clog2(BUF_BITS + 1);
  localparam int POS_W      = $clog2(BUF_BITS);
  localparam int OP_MAX     = 32;
  localparam int OPPOS_W    = $clog2(OP_MAX);

  localparam logic [7:0] A_CTRL  = 8'h00;
  localparam logic [7:0] A_OPC   = 8'h04;
  localparam logic [7:0] A_DATA0 = 8'h08;
  localparam logic [7:0] A_CFG   = 8'h28;
  localparam logic [7:0] A_LEN   = 8'h2C;
  localparam logic [7:0] A_CS    = 8'h38;

  typedef enum logic [1:0] {PH_IDLE, PH_OP, PH_TX, PH_RX} phase_e;

  typedef struct packed {
    logic               busy;
    phase_e             phase;
    logic [IDX_W-1:0]   bitIdx;
    logic [OPPOS_W-1:0] opPos;
    logic               sampleEn;
  } strobe_t;
endpackage

// File: rtl/spim_ctrl.sv
module spim_ctrl
  import spim_pkg::*;
#(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [7:0]       opLenIn,
  input  logic [11:0]      txLenIn,
  input  logic [11:0]      rxLenIn,
  input  logic [DIV_W-1:0] divIn,
  input  logic             cpol,
  input  logic             cpha,
  output strobe_t          stb,
  output logic             sck
);
  localparam int CNT_W = DIV_W + 1;

  phase_e           phase, firstPhase, nextPhase;
  logic [IDX_W-1:0] bitIdx, opLen, txLen, rxLen, curLen;
  logic [IDX_W-1:0] opC, txC, rxC;
  logic [DIV_W-1:0] divLat;
  logic [CNT_W-1:0] divCnt, lastCnt, half, halfM1;
  logic             busy;

  // length clamping (R10)
  assign opC = (opLenIn > 8'(OP_MAX)) ? IDX_W'(OP_MAX) : IDX_W'(opLenIn);
  assign txC = (txLenIn > 12'(BUF_BITS)) ? IDX_W'(BUF_BITS) : txLenIn[IDX_W-1:0];
  assign rxC = (rxLenIn > 12'(BUF_BITS)) ? IDX_W'(BUF_BITS) : rxLenIn[IDX_W-1:0];

  assign busy    = (phase != PH_IDLE);
  assign lastCnt = CNT_W'(divLat) + CNT_W'(1);
  assign half    = (CNT_W'(divLat) + CNT_W'(2)) >> 1;
  assign halfM1  = half - CNT_W'(1);

  always_comb begin
    if (opC != '0)      firstPhase = PH_OP;
    else if (txC != '0) firstPhase = PH_TX;
    else if (rxC != '0) firstPhase = PH_RX;
    else                firstPhase = PH_IDLE;
  end

  always_comb begin
    nextPhase = PH_IDLE;
    curLen    = '0;
    unique case (phase)
      PH_OP: begin
        curLen = opLen;
        if (txLen != '0)      nextPhase = PH_TX;
        else if (rxLen != '0) nextPhase = PH_RX;
      end
      PH_TX: begin
        curLen = txLen;
        if (rxLen != '0) nextPhase = PH_RX;
      end
      PH_RX:   curLen = rxLen;
      default: curLen = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= PH_IDLE;
      bitIdx <= '0;
      divCnt <= '0;
      opLen  <= '0;
      txLen  <= '0;
      rxLen  <= '0;
      divLat <= '0;
    end else if (!busy) begin
      if (startReq) begin
        phase  <= firstPhase;
        bitIdx <= '0;
        divCnt <= '0;
        opLen  <= opC;
        txLen  <= txC;
        rxLen  <= rxC;
        divLat <= divIn;
      end
    end else if (divCnt == lastCnt) begin
      divCnt <= '0;
      if (bitIdx + IDX_W'(1) < curLen) begin
        bitIdx <= bitIdx + IDX_W'(1);
      end else begin
        bitIdx <= '0;
        phase  <= nextPhase;
      end
    end else begin
      divCnt <= divCnt + CNT_W'(1);
    end
  end

  assign stb.busy     = busy;
  assign stb.phase    = phase;
  assign stb.bitIdx   = bitIdx;
  assign stb.opPos    = OPPOS_W'(opLen - bitIdx - IDX_W'(1));
  assign stb.sampleEn = (phase == PH_RX) && (divCnt == halfM1);

  assign sck = busy ? (cpol ^ ((divCnt < half) ? cpha : ~cpha)) : cpol;

  p_start_accept_r2: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && !busy && ((opC | txC | rxC) != '0)) |=> busy);
  p_ignore_busy_start_r3: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && busy) |=> ($stable(opLen) && $stable(txLen) && $stable(rxLen)));
  p_bit_in_range_r4: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (bitIdx < curLen));
  p_divcnt_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (divCnt <= lastCnt));
  p_sck_rests_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (sck == cpol));
endmodule

// File: rtl/spim_dp.sv
module spim_dp
  import spim_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int DIV_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        busAddr,
  input  logic              busWrEn,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  input  strobe_t           stb,
  input  logic              miso,
  output logic              mosi,
  output logic [NUM_CS-1:0] csN,
  output logic              startReq,
  output logic [7:0]        opLen,
  output logic [11:0]       txLen,
  output logic [11:0]       rxLen,
  output logic [DIV_W-1:0]  div,
  output logic              cpol,
  output logic              cpha
);
  logic [31:0]         opcodeReg, lenReg;
  logic [BUF_BITS-1:0] dataBuf;
  logic [NUM_CS-1:0]   csReg;
  logic                lsbFirst;
  logic [POS_W-1:0]    bitPos;
  logic                unusedIdxTop;

  function automatic logic [POS_W-1:0] mapPos(input logic [IDX_W-1:0] idx, input logic lsb);
    return {idx[POS_W-1:3], (lsb ? idx[2:0] : ~idx[2:0])};
  endfunction

  assign bitPos       = mapPos(stb.bitIdx, lsbFirst);
  assign unusedIdxTop = stb.bitIdx[IDX_W-1];
  assign startReq     = busWrEn && (busAddr == A_CTRL) && busWrData[8];
  assign opLen        = lenReg[31:24];
  assign rxLen        = lenReg[23:12];
  assign txLen        = lenReg[11:0];
  assign csN          = ~csReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opcodeReg <= '0;
      lenReg    <= '0;
      dataBuf   <= '0;
      csReg     <= '0;
      lsbFirst  <= 1'b0;
      cpol      <= 1'b0;
      cpha      <= 1'b0;
      div       <= '0;
    end else begin
      if (busWrEn) begin
        unique case (busAddr)
          A_OPC: opcodeReg <= busWrData;
          A_LEN: lenReg    <= busWrData;
          A_CS:  csReg     <= busWrData[NUM_CS-1:0];
          A_CFG: begin
            lsbFirst <= busWrData[3];
            cpol     <= busWrData[4];
            cpha     <= busWrData[5];
            div      <= busWrData[16 +: DIV_W];
          end
          default: ;
        endcase
      end
      for (int w = 0; w < DATA_WORDS; w++) begin
        if (busWrEn && (busAddr == A_DATA0 + 8'(4 * w)))
          dataBuf[w*32 +: 32] <= busWrData;
      end
      if (stb.sampleEn) dataBuf[bitPos] <= miso;
    end
  end

  always_comb begin
    unique case (stb.phase)
      PH_OP:   mosi = opcodeReg[stb.opPos];
      PH_TX:   mosi = dataBuf[bitPos];
      default: mosi = 1'b0;
    endcase
  end

  always_comb begin
    busRdData = '0;
    unique case (busAddr)
      A_CTRL: busRdData[16] = stb.busy;
      A_OPC:  busRdData = opcodeReg;
      A_LEN:  busRdData = lenReg;
      A_CS:   busRdData[NUM_CS-1:0] = csReg;
      A_CFG: begin
        busRdData[3]          = lsbFirst;
        busRdData[4]          = cpol;
        busRdData[5]          = cpha;
        busRdData[16 +: DIV_W] = div;
      end
      default: begin
        for (int w = 0; w < DATA_WORDS; w++)
          if (busAddr == A_DATA0 + 8'(4 * w)) busRdData = dataBuf[w*32 +: 32];
      end
    endcase
  end

  p_rx_mosi_low_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.phase == PH_RX) |-> !mosi);
  p_cs_follows_r9: assert property (@(posedge clk) disable iff (!rstN)
    $past(busWrEn && (busAddr == A_CS)) |-> (csN == ~$past(busWrData[NUM_CS-1:0])));
endmodule

// File: rtl/spim_top.sv
module spim_top
  import spim_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int DIV_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        busAddr,
  input  logic              busWrEn,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  output logic              spiSck,
  output logic              spiMosi,
  input  logic              spiMiso,
  output logic [NUM_CS-1:0] spiCsN
);
  strobe_t          stb;
  logic             startReq, cpol, cpha;
  logic [7:0]       opLen;
  logic [11:0]      txLen, rxLen;
  logic [DIV_W-1:0] div;

  spim_dp #(.NUM_CS(NUM_CS), .DIV_W(DIV_W)) uDp (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .stb(stb), .miso(spiMiso),
    .mosi(spiMosi), .csN(spiCsN), .startReq(startReq), .opLen(opLen),
    .txLen(txLen), .rxLen(rxLen), .div(div), .cpol(cpol), .cpha(cpha)
  );

  spim_ctrl #(.DIV_W(DIV_W)) uCtrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .opLenIn(opLen),
    .txLenIn(txLen), .rxLenIn(rxLen), .divIn(div), .cpol(cpol), .cpha(cpha),
    .stb(stb), .sck(spiSck)
  );
endmodule

// File: tb/tb_spim_top.sv
module tb_spim_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        spiSck, spiMosi;
  logic        spiMiso = 1'b0;
  logic [3:0]  spiCsN;

  int total = 0, bad = 0;
  bit finished = 0;

  // slave model state
  bit   armed = 0;
  bit   mCpol = 0, mCpha = 0;
  int   preBits = 0, rxN = 0, sampleCnt = 0;
  int   armTick = 0, lastArm = 0;
  logic lastSck = 1'bx;
  bit   mosiCap [0:1023];
  bit   rxSrc   [0:511];

  always #4 clk = ~clk;

  spim_top dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .spiSck(spiSck),
    .spiMosi(spiMosi), .spiMiso(spiMiso), .spiCsN(spiCsN)
  );

  always @(spiSck or armTick) begin
    if (armTick != lastArm) begin
      lastArm   = armTick;
      sampleCnt = 0;
    end
    if (spiSck !== lastSck) begin
      lastSck = spiSck;
      if (armed && (spiSck == (mCpol == mCpha))) begin
        mosiCap[sampleCnt] = spiMosi;
        sampleCnt++;
      end
    end
    if (sampleCnt - preBits >= 0 && sampleCnt - preBits < rxN)
      spiMiso = rxSrc[sampleCnt - preBits];
    else
      spiMiso = 1'b0;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdData;
  endtask

  function automatic int posOf(input int idx, input bit lsb);
    return (idx / 8) * 8 + (lsb ? idx % 8 : 7 - idx % 8);
  endfunction

  task automatic runXfer(input bit cpol, input bit cpha, input bit lsb, input int div,
                         input int opF, input int txF, input int rxF, input bit poke);
    bit [31:0] opcode;
    bit [7:0]  bytesTx [32];
    bit [7:0]  bytesExp[32];
    int op, tx, rx, n, cnt, opBad, txBad, rxBad, firstBadA, firstBadE;
    logic [31:0] rd;
    op = (opF > 32) ? 32 : opF;
    tx = (txF > 256) ? 256 : txF;
    rx = (rxF > 256) ? 256 : rxF;
    n  = op + tx + rx;
    opcode = $urandom;
    for (int i = 0; i < 32; i++) bytesTx[i] = 8'($urandom);
    for (int i = 0; i < 512; i++) rxSrc[i] = 1'($urandom);
    busWrite(8'h28, (32'(div) << 16) | (32'(cpha) << 5) | (32'(cpol) << 4) | (32'(lsb) << 3));
    busWrite(8'h04, opcode);
    for (int w = 0; w < 8; w++)
      busWrite(8'(8 + 4 * w), {bytesTx[4*w+3], bytesTx[4*w+2], bytesTx[4*w+1], bytesTx[4*w]});
    busWrite(8'h2C, (32'(opF) << 24) | (32'(rxF) << 12) | 32'(txF));
    mCpol = cpol; mCpha = cpha; preBits = op + tx; rxN = rx; armed = 1;
    armTick++;
    busWrite(8'h00, 32'h100);
    busAddr = 8'h00;
    cnt = 0;
    while (busRdData[16] === 1'b1 && cnt < 100000) begin
      cnt++;
      if (poke && cnt == 2) begin
        busAddr = 8'h00; busWrData = 32'h100; busWrEn = 1'b1;
      end else busWrEn = 1'b0;
      @(negedge clk);
      #1;
    end
    busWrEn = 1'b0;
    armed = 0;
    check(cnt == n * (div + 2), poke ? "R3" : "R7", "busy cycles", cnt, n * (div + 2));
    check(sampleCnt == n, "R8", "sample edges", sampleCnt, n);
    opBad = 0; txBad = 0; rxBad = 0; firstBadA = 0; firstBadE = 0;
    for (int j = 0; j < n && j < 1024; j++) begin
      bit e;
      if (j < op) e = opcode[op - 1 - j];
      else if (j < op + tx) begin
        int p;
        p = posOf(j - op, lsb);
        e = bytesTx[p / 8][p % 8];
      end else e = 1'b0;
      if (mosiCap[j] != e) begin
        if (j < op) opBad++; else if (j < op + tx) txBad++; else rxBad++;
      end
    end
    check(opBad == 0, "R4", "opcode bit mismatches", opBad, 0);
    check(txBad == 0, "R5", "tx bit mismatches", txBad, 0);
    check(rxBad == 0, "R6", "mosi high during rx", rxBad, 0);
    for (int i = 0; i < 32; i++) bytesExp[i] = bytesTx[i];
    for (int r = 0; r < rx; r++) begin
      int p;
      p = posOf(r, lsb);
      bytesExp[p / 8][p % 8] = rxSrc[r];
    end
    for (int w = 0; w < 8; w++) begin
      logic [31:0] e;
      e = {bytesExp[4*w+3], bytesExp[4*w+2], bytesExp[4*w+1], bytesExp[4*w]};
      busRead(8'(8 + 4 * w), rd);
      if (rd != e && firstBadA == 0) begin
        firstBadA = 1;
        check(0, "R6", $sformatf("rx buffer word %0d", w), rd, e);
      end
    end
    if (firstBadA == 0) check(1, "R6", "rx buffer", 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    void'($urandom(32'd24681));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    // reset state
    busRead(8'h00, rd);
    check(rd == 32'h0, "R2", "control after reset", rd, 0);
    check(spiCsN == 4'hF, "R9", "cs after reset", spiCsN, 4'hF);
    check(spiSck == 1'b0, "R8", "sck after reset", spiSck, 0);
    // register readback
    busWrite(8'h28, 32'hFFFF_FFFF);
    busRead(8'h28, rd);
    check(rd == 32'h0FFF_0038, "R1", "config readback", rd, 32'h0FFF_0038);
    check(spiSck == 1'b1, "R8", "sck idles at polarity 1", spiSck, 1);
    busWrite(8'h2C, 32'h1234_5678);
    busRead(8'h2C, rd);
    check(rd == 32'h1234_5678, "R1", "lengths readback", rd, 32'h1234_5678);
    busWrite(8'h28, 32'h0);
    // chip select
    busWrite(8'h38, 32'h5);
    check(spiCsN == 4'b1010, "R9", "cs drive", spiCsN, 4'b1010);
    // zero length start
    busWrite(8'h2C, 32'h0);
    busWrite(8'h00, 32'h100);
    busRead(8'h00, rd);
    check(rd[16] == 1'b0, "R11", "busy after empty start", rd[16], 0);
    check(spiSck == 1'b0, "R11", "sck after empty start", spiSck, 0);
    // directed modes
    runXfer(0, 0, 0, 0, 8, 16, 0, 0);
    check(spiCsN == 4'b1010, "R9", "cs held across transfer", spiCsN, 4'b1010);
    runXfer(0, 1, 0, 1, 24, 0, 16, 0);
    runXfer(1, 0, 1, 2, 0, 12, 9, 0);
    runXfer(1, 1, 1, 3, 5, 0, 0, 0);
    runXfer(0, 0, 1, 0, 32, 8, 8, 1);       // start while busy
    runXfer(1, 1, 0, 4095, 3, 0, 1, 0);     // largest divider
    runXfer(0, 1, 0, 0, 40, 300, 300, 0);   // clamped lengths R10
    // random mix
    for (int k = 0; k < 24; k++) begin
      int o, t, r;
      o = $urandom % 33; t = $urandom % 80; r = $urandom % 80;
      if (o + t + r == 0) r = 8;
      runXfer(1'($urandom), 1'($urandom), 1'($urandom), $urandom % 4, o, t, r, 0);
    end
    busWrite(8'h38, 32'h0);
    check(spiCsN == 4'hF, "R9", "cs release", spiCsN, 4'hF);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule